// File: doc/BRIEF.md
# Cascadable Multichannel Output Summer

This block forms the single wideband output word of a multichannel digital up-converter. Each clock it adds the signed samples of four channel paths to an 18-bit word from an upstream device in the chain. The sum is then scaled by a programmable right shift and reduced to 18 bits, either by saturating or by wrapping. Last, it is coded as two's complement or offset binary. The result is registered and driven onto a tri-state bus, so several devices can be chained by wiring one device's output into the next one's cascade input.

In complex mode, I and Q samples share the bus on alternating words. A Q flag goes out with each Q word. The flag follows the channel phase indication when channel samples are valid, and follows the cascade Q indicator otherwise. The channel filters, oscillators and converter lie outside this block.

Top module: `chsum_top`

## Requirements
- R1: Output data equals the sum of the four channel samples and the cascade word, after scaling, overrange handling and coding, and appears one clock after the inputs.
- R2: While `ch_valid_i` is low the channel samples contribute zero and only the cascade word is summed.
- R3: The sum is formed with 3 guard bits (21 bits), so five full-scale terms of either sign are added exactly before scaling.
- R4: `scale_i` (0 to 3) shifts the sum arithmetically right by that many bits, rounding toward minus infinity.
- R5: With `clip_en_i` high, a scaled value above 131071 gives 131071 and one below -131072 gives -131072.
- R6: With `clip_en_i` low, the output keeps the low 18 bits of the scaled value (wraps modulo 2^18).
- R7: With `offset_bin_i` high, bit 17 of the two's complement result is inverted and all other bits pass unchanged.
- R8: `q_o` is high exactly when `complex_en_i` is high and the word is a Q sample: `ch_q_i` when `ch_valid_i` is high, `casc_q_i` otherwise. It updates on the same edge as its data word.
- R9: With `oe_i` low, `dout_o` and `q_o` are both high impedance.
- R10: After reset the output register holds 0 and the Q flag is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ch_data_i | input | 72 | Four signed 18-bit channel samples, channel k at bits 18k+17..18k |
| ch_valid_i | input | 1 | Channel samples valid this cycle |
| ch_q_i | input | 1 | Channel samples are Q-phase |
| casc_data_i | input | 18 | Signed cascade word from upstream device |
| casc_q_i | input | 1 | Cascade word is a Q sample |
| scale_i | input | 2 | Right-shift amount applied to the sum |
| clip_en_i | input | 1 | 1: saturate on overrange, 0: wrap |
| offset_bin_i | input | 1 | 1: offset binary output, 0: two's complement |
| complex_en_i | input | 1 | Complex (interleaved I/Q) output mode |
| oe_i | input | 1 | Output enable, active high |
| dout_o | output | 18 | Wideband output data, tri-state |
| q_o | output | 1 | Q sample indicator, tri-state |

## Verification
The bench builds the block with its defaults: four channels and an 18-bit word, which gives a 21-bit internal sum and a 2-bit shift. At this size every term can be driven to either full-scale limit at once. That makes the largest positive and negative sums reachable, so both saturation limits and the wrapped residues can be compared against exact integers. The shift range 0 to 3 is small enough to cover every scale setting, including odd negative sums where arithmetic rounding shows.

// File: rtl/chsum_pkg.sv
package chsum_pkg;
  typedef enum logic {OVR_WRAP = 1'b0, OVR_CLIP = 1'b1} ovr_mode_e;
  typedef enum logic {CODE_TWOS = 1'b0, CODE_OFFSET = 1'b1} out_code_e;
endpackage

// File: rtl/chsum_tree.sv
module chsum_tree #(
  parameter int NUM_CH = 4,
  parameter int DW     = 18,
  parameter int SW     = 21
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NUM_CH*DW-1:0]     ch_data_i,
  input  logic                     ch_valid_i,
  input  logic [DW-1:0]            casc_data_i,
  output logic signed [SW-1:0]     sum_o
);
  logic signed [SW-1:0] ext [NUM_CH];

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ext
    assign ext[k] = {{(SW-DW){ch_data_i[k*DW+DW-1]}}, ch_data_i[k*DW +: DW]};
  end

  always_comb begin
    sum_o = {{(SW-DW){casc_data_i[DW-1]}}, casc_data_i};
    for (int k = 0; k < NUM_CH; k++) begin
      if (ch_valid_i) sum_o = sum_o + ext[k];
    end
  end

  // idle channels and zero cascade must give a zero sum
  assert_idle_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ch_valid_i && casc_data_i == '0) |-> sum_o == '0);
endmodule

// File: rtl/chsum_ovr.sv
module chsum_ovr
  import chsum_pkg::*;
#(
  parameter int DW  = 18,
  parameter int SW  = 21,
  parameter int SHW = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic signed [SW-1:0] sum_i,
  input  logic [SHW-1:0]       shift_i,
  input  ovr_mode_e            mode_i,
  output logic [DW-1:0]        res_o
);
  localparam logic signed [SW-1:0] MAXV = {{(SW-DW+1){1'b0}}, {(DW-1){1'b1}}};
  localparam logic signed [SW-1:0] MINV = {{(SW-DW+1){1'b1}}, {(DW-1){1'b0}}};

  logic signed [SW-1:0] scaled;
  assign scaled = sum_i >>> shift_i;

  always_comb begin
    res_o = scaled[DW-1:0];
    if (mode_i == OVR_CLIP) begin
      if (scaled > MAXV)      res_o = MAXV[DW-1:0];
      else if (scaled < MINV) res_o = MINV[DW-1:0];
    end
  end

  // saturation never flips the sign of the scaled sum
  assert_clip_sign_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == OVR_CLIP) |-> res_o[DW-1] == scaled[SW-1]);
endmodule

// File: rtl/chsum_fmt.sv
module chsum_fmt
  import chsum_pkg::*;
#(
  parameter int DW = 18
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] res_i,
  input  out_code_e     code_i,
  output logic [DW-1:0] code_o
);
  always_comb begin
    code_o = res_i;
    if (code_i == CODE_OFFSET) code_o[DW-1] = ~res_i[DW-1];
  end

  assert_code_low_bits_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    code_o[DW-2:0] == res_i[DW-2:0]);
endmodule

// File: rtl/chsum_top.sv
module chsum_top
  import chsum_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DW     = 18,
  parameter int SHW    = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_CH*DW-1:0] ch_data_i,
  input  logic                 ch_valid_i,
  input  logic                 ch_q_i,
  input  logic [DW-1:0]        casc_data_i,
  input  logic                 casc_q_i,
  input  logic [SHW-1:0]       scale_i,
  input  logic                 clip_en_i,
  input  logic                 offset_bin_i,
  input  logic                 complex_en_i,
  input  logic                 oe_i,
  output logic [DW-1:0]        dout_o,
  output logic                 q_o
);
  localparam int GUARD = $clog2(NUM_CH + 1);
  localparam int SW    = DW + GUARD;

  logic signed [SW-1:0] sum;
  logic [DW-1:0]        res, code, out_q;
  logic                 q_d, q_q;

  chsum_tree #(.NUM_CH(NUM_CH), .DW(DW), .SW(SW)) u_tree (
    .clk_i, .rst_ni, .ch_data_i, .ch_valid_i, .casc_data_i, .sum_o(sum)
  );

  chsum_ovr #(.DW(DW), .SW(SW), .SHW(SHW)) u_ovr (
    .clk_i, .rst_ni, .sum_i(sum), .shift_i(scale_i),
    .mode_i(ovr_mode_e'(clip_en_i)), .res_o(res)
  );

  chsum_fmt #(.DW(DW)) u_fmt (
    .clk_i, .rst_ni, .res_i(res), .code_i(out_code_e'(offset_bin_i)), .code_o(code)
  );

  assign q_d = complex_en_i & (ch_valid_i ? ch_q_i : casc_q_i);

  // data word and its Q flag share one edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q <= '0;
      q_q   <= 1'b0;
    end else begin
      out_q <= code;
      q_q   <= q_d;
    end
  end

  assign dout_o = oe_i ? out_q : 'z;
  assign q_o    = oe_i ? q_q   : 1'bz;

  assert_real_no_q_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !complex_en_i |=> !q_q);
endmodule

// File: tb/chsum_top_bench.sv
module chsum_top_bench;
  localparam int DW = 18;
  localparam int NC = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NC*DW-1:0] ch_data = '0;
  logic ch_valid = 1'b0, ch_q = 1'b0, casc_q = 1'b0;
  logic [DW-1:0] casc = '0;
  logic [1:0] scale = '0;
  logic clip = 1'b0, offs = 1'b0, cplx = 1'b0, oe = 1'b1;
  wire [DW-1:0] dout;
  wire q_w;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  for (genvar b = 0; b < DW; b++) begin : g_pu
    pullup (dout[b]);
  end
  pulldown (q_w);

  chsum_top u_chsum_top (
    .clk_i(clk), .rst_ni(rst_n), .ch_data_i(ch_data), .ch_valid_i(ch_valid),
    .ch_q_i(ch_q), .casc_data_i(casc), .casc_q_i(casc_q), .scale_i(scale),
    .clip_en_i(clip), .offset_bin_i(offs), .complex_en_i(cplx), .oe_i(oe),
    .dout_o(dout), .q_o(q_w)
  );

  function automatic logic [DW-1:0] model(int c0, int c1, int c2, int c3, int cs,
                                          bit v, int sh, bit cl, bit ob);
    int s;
    logic [DW-1:0] r;
    s = cs + (v ? c0 + c1 + c2 + c3 : 0);
    s = s >>> sh;
    if (cl) begin
      if (s > 131071) s = 131071;
      if (s < -131072) s = -131072;
    end
    r = s[DW-1:0];
    if (ob) r[DW-1] = ~r[DW-1];
    return r;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_vec(string req, int c0, int c1, int c2, int c3, int cs,
                         bit v, bit chq, bit csq, int sh, bit cl, bit ob, bit cx);
    logic [DW-1:0] e;
    bit eq;
    @(negedge clk);
    ch_data = {DW'(c3), DW'(c2), DW'(c1), DW'(c0)};
    casc = DW'(cs); ch_valid = v; ch_q = chq; casc_q = csq;
    scale = 2'(sh); clip = cl; offs = ob; cplx = cx;
    e = model(c0, c1, c2, c3, cs, v, sh, cl, ob);
    eq = cx & (v ? chq : csq);
    @(posedge clk);
    @(negedge clk);
    check({req, " data"}, 32'(dout), 32'(e));
    check({req, " qflag"}, 32'(q_w), 32'(eq));
  endtask

  task automatic t_reset;
    check("R10 reset data", 32'(dout), 32'h0);
    check("R10 reset qflag", 32'(q_w), 32'h0);
  endtask

  task automatic t_basic_sum;
    run_vec("R1 mixed", 100, -40, 7, 3000, -500, 1, 0, 0, 0, 1, 0, 0);
    run_vec("R1 negatives", -9000, -1, -2, -3, 12, 1, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_idle;
    run_vec("R2 idle channels", 50000, 50000, 50000, 50000, -77, 0, 0, 0, 0, 1, 0, 0);
  endtask

  task automatic t_guard;
    run_vec("R3 max positive", 131071, 131071, 131071, 131071, 131071, 1, 0, 0, 3, 1, 0, 0);
    run_vec("R3 max negative", -131072, -131072, -131072, -131072, -131072, 1, 0, 0, 3, 1, 0, 0);
  endtask

  task automatic t_scale;
    run_vec("R4 shift1 odd neg", -5, 0, 0, 0, 0, 1, 0, 0, 1, 1, 0, 0);
    run_vec("R4 shift2", 1000, 24, 0, 0, 0, 1, 0, 0, 2, 1, 0, 0);
    run_vec("R4 shift3 neg", -7, 0, 0, 0, -10, 1, 0, 0, 3, 1, 0, 0);
  endtask

  task automatic t_clip;
    run_vec("R5 clip high", 131071, 131071, 131071, 131071, 131071, 1, 0, 0, 0, 1, 0, 0);
    run_vec("R5 clip low", -131072, -131072, -131072, -131072, -131072, 1, 0, 0, 2, 1, 0, 0);
    run_vec("R5 edge in range", 131071, 0, 0, 0, 0, 1, 0, 0, 0, 1, 0, 0);
  endtask

  task automatic t_wrap;
    run_vec("R6 wrap high", 131071, 131071, 131071, 131071, 131071, 1, 0, 0, 0, 0, 0, 0);
    run_vec("R6 wrap low", -131072, -131072, -131072, -131072, -131072, 1, 0, 0, 2, 0, 0, 0);
  endtask

  task automatic t_offset;
    run_vec("R7 offset zero", 0, 0, 0, 0, 0, 1, 0, 0, 0, 1, 1, 0);
    run_vec("R7 offset neg", -3, 0, 0, 0, 0, 1, 0, 0, 0, 1, 1, 0);
    run_vec("R7 offset clip", 131071, 131071, 0, 0, 0, 1, 0, 0, 0, 1, 1, 0);
  endtask

  task automatic t_complex;
    run_vec("R8 I word", 10, 20, 30, 40, 5, 1, 0, 1, 0, 1, 0, 1);
    run_vec("R8 Q word", -10, 20, 30, 40, 5, 1, 1, 0, 0, 1, 0, 1);
    run_vec("R8 cascade Q", 0, 0, 0, 0, 321, 0, 0, 1, 0, 1, 0, 1);
    run_vec("R8 real ignores q", 1, 2, 3, 4, 5, 1, 1, 1, 0, 1, 0, 0);
  endtask

  task automatic t_oe;
    run_vec("R9 setup", 1, 0, 0, 0, 0, 1, 1, 0, 0, 1, 0, 1);
    oe = 1'b0;
    #1;
    check("R9 data hi-z", 32'(dout), 32'h3FFFF);
    check("R9 qflag hi-z", 32'(q_w), 32'h0);
    oe = 1'b1;
    #1;
    check("R9 re-enabled", 32'(dout), 32'h1);
  endtask

  initial begin
    #200000ns;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    t_basic_sum;
    t_idle;
    t_guard;
    t_scale;
    t_clip;
    t_wrap;
    t_offset;
    t_complex;
    t_oe;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule